// File: doc/BRIEF.md
# Virtual Interrupt-Command and Register-MSR Write Checker

This block sits behind the trap logic of a virtualized interrupt controller. When a guest write to the interrupt command register page has been trapped, or when a guest writes one of the register-mapped MSRs, the block decides what the write means. Depending on the write, it becomes one of these:

- a self-targeted interrupt request;
- an update of the task-priority register;
- an end-of-interrupt update;
- a rewrite of the high command word;
- a general-protection fault;
- an exit to the hypervisor that carries a page offset.

It holds no interrupt state of its own. The request, pending and end-of-service vectors live in a neighbouring block that consumes the strobes produced here.

Each input event is a one-cycle valid pulse with its payload. All results are registered and appear as one-cycle strobes on the cycle after the event. Only one action class is raised per event. A trapped page write and an MSR write presented in the same cycle are resolved in favour of the trapped page write.

Top module: `vicr_msr_chk`

## Requirements
- R1: A trapped write at offset 0x300 with `virt_dlv_en` high becomes a self-interrupt request (`sipi_req`, vector in `res_data[7:0]`) when all three of these hold: the value ANDed with 0xFFF3B700 is zero, bits [19:18] equal 01, and bits [7:0] are at least 16. Bits 14 and 11 do not block it.
- R2: A trapped write at offset 0x300 that fails any condition of R1, or arrives while `virt_dlv_en` is low, raises `exit_req` with `exit_off` = 0x300 and no self-interrupt request.
- R3: A trapped write at any offset from 0x310 to 0x313 raises `icrhi_wr` with `res_data` = {`icr_hi_val[31:24]`, 24'h0} and raises no exit.
- R4: A trapped write at any other offset raises `exit_req` with `exit_off` equal to that offset.
- R5: When a trapped write arrives with `trap_pend_tpr` high, only `tpr_upd` is raised. When it arrives with `trap_pend_eoi` high and `trap_pend_tpr` low, only `eoi_upd` is raised. Offset decoding applies only when neither flag is high.
- R6: An MSR write to index 0x808 raises `gp_fault` if any of value bits [63:8] is set. Otherwise it raises both `tpr_wr` and `tpr_upd` with `res_data` = value[7:0] zero-extended. This holds whatever the state of `virt_dlv_en`.
- R7: With `virt_dlv_en` high, an MSR write to index 0x80B raises `gp_fault` on a nonzero value and raises `eoi_upd` on a zero value.
- R8: With `virt_dlv_en` high, an MSR write to index 0x83F behaves as follows:
  - any of value bits [63:8] set: `gp_fault`;
  - a vector below 16: `sipireg_wr` together with `exit_req`, `exit_off` = 0x3F0 and `res_data` = vector;
  - a vector of 16 or more: `sipi_req` with that vector.
- R9: An MSR write to an index not handled by R6 to R8, or to 0x80B or 0x83F while `virt_dlv_en` is low, raises only `msr_unclaimed`.
- R10: If `trap_vld` and `msr_vld` are high in the same cycle, the trapped write is processed and the MSR write is ignored.
- R11: Every output strobe is high for exactly the one cycle after the clock edge that sampled its event. A cycle with no event produces no strobe in the next cycle. All strobes are low during and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_vld | input | 1 | Trapped page-write event |
| trap_pend_tpr | input | 1 | A task-priority update is pending for this trap |
| trap_pend_eoi | input | 1 | An end-of-interrupt update is pending for this trap |
| trap_off | input | 10 | Page offset of the trapped write |
| icr_lo_val | input | 32 | Current low command word |
| icr_hi_val | input | 32 | Current high command word |
| msr_vld | input | 1 | MSR write event |
| msr_idx | input | MSR_W | MSR index |
| msr_val | input | 64 | MSR write value |
| virt_dlv_en | input | 1 | Virtual interrupt delivery enabled |
| sipi_req | output | 1 | Self-interrupt request, vector in res_data[7:0] |
| tpr_wr | output | 1 | Write res_data to task priority, upper word cleared |
| tpr_upd | output | 1 | Task-priority update event |
| eoi_upd | output | 1 | End-of-interrupt update event |
| icrhi_wr | output | 1 | Write res_data to the high command word |
| sipireg_wr | output | 1 | Store res_data[7:0] in the self-interrupt register |
| gp_fault | output | 1 | General-protection fault request |
| exit_req | output | 1 | Exit request |
| exit_off | output | 10 | Page offset reported with the exit |
| msr_unclaimed | output | 1 | MSR index not handled here |
| res_data | output | 32 | Data that accompanies the strobe |

## Verification
The block's only state is the registered action word, so a wrong decode shows at the ports exactly one cycle after the event. That wrong decode appears either as a wrong strobe class or as wrong `res_data` or `exit_off`. A strobe that fails to clear, or one that survives an idle cycle, shows as a second high cycle on the following edge. The stimulus walks each qualification bit of the command word on its own, the vector 15/16 boundary, both edges of the high-word byte range and the three-way pending priority. This ensures that a single mis-decoded bit changes a visible output.

// File: rtl/vicr_pkg.sv
package vicr_pkg;
  localparam int OFF_W = 10;
  localparam int DAT_W = 32;

  localparam logic [OFF_W-1:0] OFF_CMD_LO   = 10'h300;
  localparam logic [OFF_W-1:0] OFF_CMD_HI   = 10'h310;
  localparam logic [OFF_W-1:0] OFF_SELF_REG = 10'h3F0;

  localparam logic [DAT_W-1:0] CMD_LO_RSVD  = 32'hFFF3_B700;
  localparam logic [1:0]       SHORT_SELF   = 2'b01;

  localparam logic [11:0] IDX_PRIO = 12'h808;
  localparam logic [11:0] IDX_EOI  = 12'h80B;
  localparam logic [11:0] IDX_SELF = 12'h83F;

  localparam int N_STB = 9;

  typedef struct packed {
    logic             sipi;
    logic             tpr_wr;
    logic             tpr_upd;
    logic             eoi_upd;
    logic             icrhi_wr;
    logic             sipireg_wr;
    logic             gp;
    logic             exit_req;
    logic             nclaim;
    logic [OFF_W-1:0] exit_off;
    logic [DAT_W-1:0] data;
  } act_t;

  localparam act_t ACT_NONE = '0;
endpackage

// File: rtl/vicr_lo_qual.sv
module vicr_lo_qual
  import vicr_pkg::*;
#(
  parameter int VEC_MIN = 16
) (
  input  logic             dlv_en,
  input  logic [DAT_W-1:0] cmd_lo,
  output logic             self_ok
);
  logic rsvd_clear;
  logic short_self;
  logic vec_ok;

  always_comb begin
    rsvd_clear = ((cmd_lo & CMD_LO_RSVD) == '0);
    short_self = (cmd_lo[19:18] == SHORT_SELF);
    vec_ok     = ({24'h0, cmd_lo[7:0]} >= VEC_MIN);
    self_ok    = dlv_en && rsvd_clear && short_self && vec_ok;
  end
endmodule

// File: rtl/vicr_trap_dec.sv
module vicr_trap_dec
  import vicr_pkg::*;
#(
  parameter int VEC_MIN = 16
) (
  input  logic             pend_tpr,
  input  logic             pend_eoi,
  input  logic [OFF_W-1:0] off,
  input  logic [DAT_W-1:0] cmd_lo,
  input  logic [DAT_W-1:0] cmd_hi,
  input  logic             dlv_en,
  output act_t             act
);
  logic self_ok;

  vicr_lo_qual #(.VEC_MIN(VEC_MIN)) u_qual (
    .dlv_en  (dlv_en),
    .cmd_lo  (cmd_lo),
    .self_ok (self_ok)
  );

  always_comb begin
    act = ACT_NONE;
    if (pend_tpr) begin
      act.tpr_upd = 1'b1;
    end else if (pend_eoi) begin
      act.eoi_upd = 1'b1;
    end else if (off[OFF_W-1:2] == OFF_CMD_HI[OFF_W-1:2]) begin
      act.icrhi_wr = 1'b1;
      act.data     = {cmd_hi[31:24], 24'h0};
    end else if (off == OFF_CMD_LO) begin
      if (self_ok) begin
        act.sipi = 1'b1;
        act.data = {24'h0, cmd_lo[7:0]};
      end else begin
        act.exit_req = 1'b1;
        act.exit_off = OFF_CMD_LO;
      end
    end else begin
      act.exit_req = 1'b1;
      act.exit_off = off;
    end
  end
endmodule

// File: rtl/vicr_msr_dec.sv
module vicr_msr_dec
  import vicr_pkg::*;
#(
  parameter int MSR_W   = 32,
  parameter int VEC_MIN = 16
) (
  input  logic [MSR_W-1:0] idx,
  input  logic [63:0]      val,
  input  logic             dlv_en,
  output act_t             act
);
  localparam logic [MSR_W-1:0] I_PRIO = MSR_W'(IDX_PRIO);
  localparam logic [MSR_W-1:0] I_EOI  = MSR_W'(IDX_EOI);
  localparam logic [MSR_W-1:0] I_SELF = MSR_W'(IDX_SELF);

  logic upper_set;
  logic low_vec;

  always_comb begin
    upper_set = |val[63:8];
    low_vec   = ({24'h0, val[7:0]} < VEC_MIN);
    act       = ACT_NONE;
    if (idx == I_PRIO) begin
      if (upper_set) begin
        act.gp = 1'b1;
      end else begin
        act.tpr_wr  = 1'b1;
        act.tpr_upd = 1'b1;
        act.data    = {24'h0, val[7:0]};
      end
    end else if (dlv_en && idx == I_EOI) begin
      if (val != '0) act.gp      = 1'b1;
      else           act.eoi_upd = 1'b1;
    end else if (dlv_en && idx == I_SELF) begin
      if (upper_set) begin
        act.gp = 1'b1;
      end else if (low_vec) begin
        act.sipireg_wr = 1'b1;
        act.exit_req   = 1'b1;
        act.exit_off   = OFF_SELF_REG;
        act.data       = {24'h0, val[7:0]};
      end else begin
        act.sipi = 1'b1;
        act.data = {24'h0, val[7:0]};
      end
    end else begin
      act.nclaim = 1'b1;
    end
  end
endmodule

// File: rtl/vicr_msr_chk.sv
module vicr_msr_chk
  import vicr_pkg::*;
#(
  parameter int MSR_W   = 32,
  parameter int VEC_MIN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_vld,
  input  logic             trap_pend_tpr,
  input  logic             trap_pend_eoi,
  input  logic [9:0]       trap_off,
  input  logic [31:0]      icr_lo_val,
  input  logic [31:0]      icr_hi_val,
  input  logic             msr_vld,
  input  logic [MSR_W-1:0] msr_idx,
  input  logic [63:0]      msr_val,
  input  logic             virt_dlv_en,
  output logic             sipi_req,
  output logic             tpr_wr,
  output logic             tpr_upd,
  output logic             eoi_upd,
  output logic             icrhi_wr,
  output logic             sipireg_wr,
  output logic             gp_fault,
  output logic             exit_req,
  output logic [9:0]       exit_off,
  output logic             msr_unclaimed,
  output logic [31:0]      res_data
);
  act_t trap_act;
  act_t msr_act;
  act_t act_d;
  logic act_en;
  logic [N_STB-1:0] stb_d, stb_q;
  logic [OFF_W-1:0] off_q;
  logic [DAT_W-1:0] dat_q;

  vicr_trap_dec #(.VEC_MIN(VEC_MIN)) u_trap (
    .pend_tpr (trap_pend_tpr),
    .pend_eoi (trap_pend_eoi),
    .off      (trap_off),
    .cmd_lo   (icr_lo_val),
    .cmd_hi   (icr_hi_val),
    .dlv_en   (virt_dlv_en),
    .act      (trap_act)
  );

  vicr_msr_dec #(.MSR_W(MSR_W), .VEC_MIN(VEC_MIN)) u_msr (
    .idx    (msr_idx),
    .val    (msr_val),
    .dlv_en (virt_dlv_en),
    .act    (msr_act)
  );

  // next state: trapped page write wins over an MSR write
  always_comb begin
    act_en = trap_vld | msr_vld;
    if (trap_vld)     act_d = trap_act;
    else if (msr_vld) act_d = msr_act;
    else              act_d = ACT_NONE;
    stb_d = {act_d.sipi, act_d.tpr_wr, act_d.tpr_upd, act_d.eoi_upd,
             act_d.icrhi_wr, act_d.sipireg_wr, act_d.gp, act_d.exit_req,
             act_d.nclaim};
  end

  // strobes reload every cycle so they last one cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= '0;
    else        stb_q <= stb_d;
  end

  // payload loads only on an event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      dat_q <= '0;
    end else if (act_en) begin
      off_q <= act_d.exit_off;
      dat_q <= act_d.data;
    end
  end

  assign {sipi_req, tpr_wr, tpr_upd, eoi_upd, icrhi_wr, sipireg_wr,
          gp_fault, exit_req, msr_unclaimed} = stb_q;
  assign exit_off = off_q;
  assign res_data = dat_q;
endmodule

// File: rtl/vicr_msr_chk_sva.sv
module vicr_msr_chk_sva
  import vicr_pkg::*;
#(
  parameter int VEC_MIN = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        trap_vld,
  input logic        trap_pend_tpr,
  input logic        trap_pend_eoi,
  input logic [9:0]  trap_off,
  input logic [31:0] icr_hi_val,
  input logic        msr_vld,
  input logic        sipi_req,
  input logic        tpr_wr,
  input logic        tpr_upd,
  input logic        eoi_upd,
  input logic        icrhi_wr,
  input logic        sipireg_wr,
  input logic        gp_fault,
  input logic        exit_req,
  input logic [9:0]  exit_off,
  input logic        msr_unclaimed,
  input logic [31:0] res_data
);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_vld && !msr_vld) |=> !(sipi_req || tpr_wr || tpr_upd || eoi_upd ||
      icrhi_wr || sipireg_wr || gp_fault || exit_req || msr_unclaimed));

  // R11
  one_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sipi_req, tpr_upd, eoi_upd, icrhi_wr, gp_fault, exit_req, msr_unclaimed}));

  // R1
  sipi_vec_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sipi_req |-> ({24'h0, res_data[7:0]} >= VEC_MIN));

  // R3
  hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_vld && !trap_pend_tpr && !trap_pend_eoi && trap_off[9:2] == OFF_CMD_HI[9:2])
      |=> (icrhi_wr && !exit_req && res_data == {$past(icr_hi_val[31:24]), 24'h0}));

  // R5
  tpr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_vld && trap_pend_tpr) |=> (tpr_upd && !eoi_upd && !exit_req && !tpr_wr));

  // R6
  gp_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |-> !(tpr_wr || sipireg_wr || sipi_req || eoi_upd));

  // R8
  self_reg_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sipireg_wr |-> (exit_req && exit_off == OFF_SELF_REG && {24'h0, res_data[7:0]} < VEC_MIN));
endmodule

bind vicr_msr_chk vicr_msr_chk_sva #(.VEC_MIN(VEC_MIN)) u_sva (.*);

// File: tb/sim_vicr_msr_chk.sv
module sim_vicr_msr_chk;
  localparam int CLK_PER = 10;
  localparam int NV = 27;

  typedef struct packed {
    logic [7:0]  req;
    logic        tv;
    logic        pt;
    logic        pe;
    logic [9:0]  off;
    logic [31:0] lo;
    logic [31:0] hi;
    logic        mv;
    logic        vd;
    logic [11:0] idx;
    logic [63:0] val;
    logic [8:0]  exf;
    logic [9:0]  exo;
    logic [31:0] exd;
  } vec_t;

  // exf bits: sipi, tpr_wr, tpr_upd, eoi_upd, icrhi_wr, sipireg_wr, gp, exit, unclaimed
  localparam vec_t TBL [NV] = '{
    // R1
    '{8'd1, 1'b1,1'b0,1'b0,10'h300,32'h0004_0031,32'h0, 1'b0,1'b1,12'h0,64'h0, 9'b100000000,10'h0,32'h31},
    // R1
    '{8'd1, 1'b1,1'b0,1'b0,10'h300,32'h0004_4831,32'h0, 1'b0,1'b1,12'h0,64'h0, 9'b100000000,10'h0,32'h31},
    // R1
    '{8'd1, 1'b1,1'b0,1'b0,10'h300,32'h0004_0010,32'h0, 1'b0,1'b1,12'h0,64'h0, 9'b100000000,10'h0,32'h10},
    // R2
    '{8'd2, 1'b1,1'b0,1'b0,10'h300,32'h0004_8031,32'h0, 1'b0,1'b1,12'h0,64'h0, 9'b000000010,10'h300,32'h0},
    // R2
    '{8'd2, 1'b1,1'b0,1'b0,10'h300,32'h000C_0031,32'h0, 1'b0,1'b1,12'h0,64'h0, 9'b000000010,10'h300,32'h0},
    // R2
    '{8'd2, 1'b1,1'b0,1'b0,10'h300,32'h0004_000F,32'h0, 1'b0,1'b1,12'h0,64'h0, 9'b000000010,10'h300,32'h0},
    // R2
    '{8'd2, 1'b1,1'b0,1'b0,10'h300,32'h0004_0031,32'h0, 1'b0,1'b0,12'h0,64'h0, 9'b000000010,10'h300,32'h0},
    // R2
    '{8'd2, 1'b1,1'b0,1'b0,10'h300,32'h0005_0031,32'h0, 1'b0,1'b1,12'h0,64'h0, 9'b000000010,10'h300,32'h0},
    // R2
    '{8'd2, 1'b1,1'b0,1'b0,10'h300,32'h0004_0131,32'h0, 1'b0,1'b1,12'h0,64'h0, 9'b000000010,10'h300,32'h0},
    // R3
    '{8'd3, 1'b1,1'b0,1'b0,10'h312,32'h0,32'hABCD_EF12, 1'b0,1'b1,12'h0,64'h0, 9'b000010000,10'h0,32'hAB00_0000},
    // R3
    '{8'd3, 1'b1,1'b0,1'b0,10'h310,32'h0,32'h1234_5678, 1'b0,1'b0,12'h0,64'h0, 9'b000010000,10'h0,32'h1200_0000},
    // R4
    '{8'd4, 1'b1,1'b0,1'b0,10'h0B0,32'h0,32'h0, 1'b0,1'b1,12'h0,64'h0, 9'b000000010,10'h0B0,32'h0},
    // R4
    '{8'd4, 1'b1,1'b0,1'b0,10'h314,32'h0,32'hFFFF_FFFF, 1'b0,1'b1,12'h0,64'h0, 9'b000000010,10'h314,32'h0},
    // R5
    '{8'd5, 1'b1,1'b1,1'b1,10'h300,32'h0004_0031,32'h0, 1'b0,1'b1,12'h0,64'h0, 9'b001000000,10'h0,32'h0},
    // R5
    '{8'd5, 1'b1,1'b0,1'b1,10'h0B0,32'h0,32'h0, 1'b0,1'b1,12'h0,64'h0, 9'b000100000,10'h0,32'h0},
    // R6
    '{8'd6, 1'b0,1'b0,1'b0,10'h0,32'h0,32'h0, 1'b1,1'b0,12'h808,64'h5A, 9'b011000000,10'h0,32'h5A},
    // R6
    '{8'd6, 1'b0,1'b0,1'b0,10'h0,32'h0,32'h0, 1'b1,1'b1,12'h808,64'h100, 9'b000000100,10'h0,32'h0},
    // R7
    '{8'd7, 1'b0,1'b0,1'b0,10'h0,32'h0,32'h0, 1'b1,1'b1,12'h80B,64'h0, 9'b000100000,10'h0,32'h0},
    // R7
    '{8'd7, 1'b0,1'b0,1'b0,10'h0,32'h0,32'h0, 1'b1,1'b1,12'h80B,64'h1, 9'b000000100,10'h0,32'h0},
    // R8
    '{8'd8, 1'b0,1'b0,1'b0,10'h0,32'h0,32'h0, 1'b1,1'b1,12'h83F,64'h45, 9'b100000000,10'h0,32'h45},
    // R8
    '{8'd8, 1'b0,1'b0,1'b0,10'h0,32'h0,32'h0, 1'b1,1'b1,12'h83F,64'h0F, 9'b000001010,10'h3F0,32'h0F},
    // R8
    '{8'd8, 1'b0,1'b0,1'b0,10'h0,32'h0,32'h0, 1'b1,1'b1,12'h83F,64'h10, 9'b100000000,10'h0,32'h10},
    // R8
    '{8'd8, 1'b0,1'b0,1'b0,10'h0,32'h0,32'h0, 1'b1,1'b1,12'h83F,64'h1_0000_0000, 9'b000000100,10'h0,32'h0},
    // R9
    '{8'd9, 1'b0,1'b0,1'b0,10'h0,32'h0,32'h0, 1'b1,1'b0,12'h83F,64'h45, 9'b000000001,10'h0,32'h0},
    // R9
    '{8'd9, 1'b0,1'b0,1'b0,10'h0,32'h0,32'h0, 1'b1,1'b0,12'h80B,64'h0, 9'b000000001,10'h0,32'h0},
    // R9
    '{8'd9, 1'b0,1'b0,1'b0,10'h0,32'h0,32'h0, 1'b1,1'b1,12'h800,64'h0, 9'b000000001,10'h0,32'h0},
    // R10
    '{8'd10, 1'b1,1'b0,1'b0,10'h0B0,32'h0,32'h0, 1'b1,1'b1,12'h808,64'h5A, 9'b000000010,10'h0B0,32'h0}
  };

  logic        clk;
  logic        rst_n;
  logic        trap_vld, trap_pend_tpr, trap_pend_eoi;
  logic [9:0]  trap_off;
  logic [31:0] icr_lo_val, icr_hi_val;
  logic        msr_vld;
  logic [31:0] msr_idx;
  logic [63:0] msr_val;
  logic        virt_dlv_en;
  logic        sipi_req, tpr_wr, tpr_upd, eoi_upd, icrhi_wr, sipireg_wr;
  logic        gp_fault, exit_req, msr_unclaimed;
  logic [9:0]  exit_off;
  logic [31:0] res_data;

  int n_chk;
  int n_err;

  vicr_msr_chk u0 (
    .clk(clk), .rst_n(rst_n),
    .trap_vld(trap_vld), .trap_pend_tpr(trap_pend_tpr), .trap_pend_eoi(trap_pend_eoi),
    .trap_off(trap_off), .icr_lo_val(icr_lo_val), .icr_hi_val(icr_hi_val),
    .msr_vld(msr_vld), .msr_idx(msr_idx), .msr_val(msr_val), .virt_dlv_en(virt_dlv_en),
    .sipi_req(sipi_req), .tpr_wr(tpr_wr), .tpr_upd(tpr_upd), .eoi_upd(eoi_upd),
    .icrhi_wr(icrhi_wr), .sipireg_wr(sipireg_wr), .gp_fault(gp_fault),
    .exit_req(exit_req), .exit_off(exit_off), .msr_unclaimed(msr_unclaimed),
    .res_data(res_data)
  );

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  function automatic logic [8:0] flags();
    return {sipi_req, tpr_wr, tpr_upd, eoi_upd, icrhi_wr, sipireg_wr,
            gp_fault, exit_req, msr_unclaimed};
  endfunction

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic idle_inputs();
    trap_vld = 1'b0; trap_pend_tpr = 1'b0; trap_pend_eoi = 1'b0; trap_off = '0;
    icr_lo_val = '0; icr_hi_val = '0; msr_vld = 1'b0; msr_idx = '0; msr_val = '0;
    virt_dlv_en = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    string rq;
    @(negedge clk);
    trap_vld = v.tv; trap_pend_tpr = v.pt; trap_pend_eoi = v.pe; trap_off = v.off;
    icr_lo_val = v.lo; icr_hi_val = v.hi; msr_vld = v.mv; virt_dlv_en = v.vd;
    msr_idx = {20'h0, v.idx}; msr_val = v.val;
    @(negedge clk);
    idle_inputs();
    rq = $sformatf("R%0d", v.req);
    check({rq, " flags"}, {23'h0, flags()}, {23'h0, v.exf});
    if (v.exf[1]) check({rq, " exit_off"}, {22'h0, exit_off}, {22'h0, v.exo});
    if (v.exf[8] | v.exf[7] | v.exf[4] | v.exf[3]) check({rq, " data"}, res_data, v.exd);
  endtask

  initial begin
    #(CLK_PER * 100000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_err = 0;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset flags", {23'h0, flags()}, 32'h0);
    check("R11 reset data", res_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle after reset", {23'h0, flags()}, 32'h0);

    for (int i = 0; i < NV; i++) run_vec(TBL[i]);

    // R11 strobe lasts one cycle
    run_vec(TBL[15]);
    @(negedge clk);
    check("R11 strobe drops", {23'h0, flags()}, 32'h0);

    // R11 back-to-back events give back-to-back strobes
    @(negedge clk);
    msr_vld = 1'b1; msr_idx = 32'h808; msr_val = 64'h21;
    @(negedge clk);
    msr_idx = 32'h900;
    check("R11 first of pair", {23'h0, flags()}, {23'h0, 9'b011000000});
    @(negedge clk);
    idle_inputs();
    check("R11 second of pair", {23'h0, flags()}, {23'h0, 9'b000000001});

    // R11 asynchronous reset clears a live strobe
    @(negedge clk);
    trap_vld = 1'b1; trap_off = 10'h0B0;
    @(negedge clk);
    idle_inputs();
    check("R11 strobe before reset", {23'h0, flags()}, {23'h0, 9'b000000010});
    #1 rst_n = 1'b0;
    #1 check("R11 async reset", {23'h0, flags()}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule